// File: doc/BRIEF.md
# Bus Master Retry Handler

This block sits on the master side of a split-transaction bus and handles the shared address-retry line. It watches transfer-start and address-acknowledge strobes to work out when a retry is valid. A retry counts only from the second cycle after a transfer start through the cycle just after the address acknowledge. It also tracks whether the address tenure in flight was started by this agent, and whether this agent's data tenure is under way.

When a valid retry arrives, the block lowers the agent's bus request in the same cycle. It blanks the incoming bus grant for that cycle and the next one. If this agent owns the retried tenure, it raises a pending reissue that stays active until the agent starts the tenure again. If this agent's data tenure has already begun, it also pulses an abort in the same cycle. An agent that only observes the retried tenure still drops its request, so that a snooping agent can push a copyback. Arbitration and data movement are handled elsewhere. All strobes are active-low and synchronous to one clock. Reset is synchronous and active-low.

Top module: `bus_retry_handler`

## Requirements
- R1: A retry (`retry_n` low) in the first cycle after a sampled transfer start (`ts_n` low) has no effect on any output. A retry from the second cycle after the transfer start onward is detected.
- R2: A retry is detected up to and including the cycle right after the sampled address acknowledge (`aack_n` low). It is ignored in the second cycle after the acknowledge and in every later cycle until the next transfer start.
- R3: In the detection cycle and the cycle after it, `req_n` is high, whether the agent owns the tenure or only observes it.
- R4: `grant_q_n` is forced high in the detection cycle and the following cycle. In every other cycle it equals `grant_n`.
- R5: `abort_n` is low for exactly the detection cycle when the agent owns the retried tenure and `dbusy_n` is low in that cycle. In all other cycles it is high.
- R6: When the agent owns the retried tenure, `reissue_n` goes low in the cycle after detection. It stays low until the cycle after the agent's next own transfer start (`ts_n` low with `ts_mine` high).
- R7: A retry of a tenure started by another agent (`ts_mine` low at its transfer start) never lowers `reissue_n` or `abort_n`.
- R8: Outside the two blackout cycles, `req_n` is the inverse of (`need_bus` OR reissue pending). The request therefore comes back no earlier than the second cycle after detection.
- R9: A retry held low across several cycles of one tenure is detected once. It does not extend the blackout or repeat the abort.
- R10: Reset forces `req_n` to the inverse of `need_bus`, `abort_n` and `reissue_n` high, and `grant_q_n` equal to `grant_n`. It also clears any pending reissue and ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| need_bus | input | 1 | Core wants the address bus |
| ts_n | input | 1 | Transfer start seen on the bus, active low |
| ts_mine | input | 1 | High when the current transfer start was driven by this agent |
| aack_n | input | 1 | Address acknowledge, active low |
| retry_n | input | 1 | Shared address retry, active low |
| grant_n | input | 1 | Bus grant from the arbiter, active low |
| dbusy_n | input | 1 | This agent's data tenure in progress, active low |
| req_n | output | 1 | Bus request to the arbiter, active low |
| grant_q_n | output | 1 | Grant after retry blanking, active low |
| abort_n | output | 1 | One-cycle data tenure abort, active low |
| reissue_n | output | 1 | Address tenure must be restarted, active low |

## Verification
Each kind of wrong internal state shows up at the ports within one or two cycles. A window tracker that is one phase off either detects the early retry one cycle after transfer start, or detects the late retry two cycles after acknowledge. Either way, `req_n` and `grant_q_n` go high in that same cycle. Wrong ownership shows up in the cycle after detection, as a missing or spurious `reissue_n`, and in the detection cycle itself as a wrong `abort_n`. A blackout counter of the wrong length, or a detection flag that is not held for the rest of the tenure, shows up as a grant that stays blanked, or a request that stays high, in the second cycle after detection.

// File: rtl/bus_retry_pkg.sv
// Package: bus_retry_pkg
// Holds the shared types of the retry handler.
// Assumes one address tenure is tracked at a time.
package bus_retry_pkg;

    // Phase of the retry sampling window for the tenure in flight
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // no tenure, or window already closed
        PH_WAIT = 2'd1,  // transfer start seen, window not yet open
        PH_OPEN = 2'd2,  // retry legal, acknowledge not yet seen
        PH_LAST = 2'd3   // cycle right after acknowledge, final legal cycle
    } rty_phase_e;

endpackage

// File: rtl/rty_window.sv
// Module: rty_window
// Tracks the legal retry sampling window of the current address tenure.
// Produces a single detection pulse per tenure. The window opens OPEN_DELAY
// cycles after a sampled transfer start and closes after the cycle that
// follows the address acknowledge.
// Assumes OPEN_DELAY >= 2, and that a new transfer start restarts tracking.
module rty_window
    import bus_retry_pkg::*;
#(
    parameter int OPEN_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ts_n,
    input  logic aack_n,
    input  logic retry_n,
    output logic hit,
    output logic win_last
);

    localparam int CW = $clog2(OPEN_DELAY + 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [CW-1:0] CNT_EDGE = CW'(OPEN_DELAY - 1);

    rty_phase_e     phase_q, phase_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           seen_q, seen_d;
    logic           win_open;

    // Window is open in the two legal phases
    always_comb begin
        win_open = (phase_q == PH_OPEN) || (phase_q == PH_LAST);
        win_last = (phase_q == PH_LAST);
        hit      = win_open && !retry_n && !seen_q;
    end

    // Next-phase logic for the sampling window
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!ts_n) begin
            phase_d = PH_WAIT;
            cnt_d   = CNT_ONE;
        end else begin
            unique case (phase_q)
                PH_WAIT: begin
                    cnt_d = cnt_q + CNT_ONE;
                    if (cnt_q == CNT_EDGE) begin
                        phase_d = aack_n ? PH_OPEN : PH_LAST;
                    end else if (!aack_n) begin
                        phase_d = PH_IDLE;
                    end
                end
                PH_OPEN: begin
                    if (!aack_n) begin
                        phase_d = PH_LAST;
                    end
                end
                PH_LAST: phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Detection flag: set on the first hit, cleared by a new transfer start
    always_comb begin
        seen_d = seen_q;
        if (!ts_n) begin
            seen_d = 1'b0;
        end else if (hit) begin
            seen_d = 1'b1;
        end
    end

    // Register window state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            seen_q  <= seen_d;
        end
    end

endmodule

// File: rtl/rty_owner.sv
// Module: rty_owner
// Records whether the tenure in flight was started by this agent. Keeps the
// pending reissue and forms the same-cycle data abort.
// Assumes hit is already qualified by the sampling window.
module rty_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic ts_n,
    input  logic ts_mine,
    input  logic hit,
    input  logic win_last,
    input  logic dbusy_n,
    output logic reissue_pend,
    output logic abort
);

    logic owner_q, owner_d;
    logic pend_q, pend_d;

    // Abort the data tenure at once when our own tenure is retried
    always_comb begin
        abort = hit && owner_q && !dbusy_n;
    end

    // Ownership follows transfer starts and ends with the window or a retry
    always_comb begin
        owner_d = owner_q;
        if (!ts_n) begin
            owner_d = ts_mine;
        end else if (hit || win_last) begin
            owner_d = 1'b0;
        end
    end

    // Reissue is set by a retry of our tenure, cleared by our next start
    always_comb begin
        pend_d = pend_q;
        if (hit && owner_q) begin
            pend_d = 1'b1;
        end else if (!ts_n && ts_mine) begin
            pend_d = 1'b0;
        end
    end

    // Register ownership and reissue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            owner_q <= owner_d;
            pend_q  <= pend_d;
        end
    end

    assign reissue_pend = pend_q;

endmodule

// File: rtl/rty_gate.sv
// Module: rty_gate
// Blanks the bus grant and withholds the bus request for BLACKOUT cycles,
// starting with the detection cycle itself.
// Assumes BLACKOUT >= 1; the detection cycle is covered combinationally.
module rty_gate #(
    parameter int BLACKOUT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic grant_n,
    input  logic need_bus,
    input  logic reissue_pend,
    output logic req_n,
    output logic grant_q_n
);

    logic tail;
    logic mask;

    generate
        if (BLACKOUT > 1) begin : g_tail
            localparam int BW = $clog2(BLACKOUT);
            localparam logic [BW-1:0] TAIL_LOAD = BW'(BLACKOUT - 1);
            logic [BW-1:0] left_q;

            // Count the blackout cycles that follow the detection cycle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q <= '0;
                end else if (hit) begin
                    left_q <= TAIL_LOAD;
                end else if (left_q != '0) begin
                    left_q <= left_q - BW'(1);
                end
            end

            assign tail = (left_q != '0);
        end else begin : g_notail
            assign tail = 1'b0;
        end
    endgenerate

    // Combine detection and tail into the blanking mask and drive outputs
    always_comb begin
        mask      = hit || tail;
        grant_q_n = grant_n || mask;
        req_n     = !((need_bus || reissue_pend) && !mask);
    end

endmodule

// File: rtl/bus_retry_handler.sv
// Module: bus_retry_handler
// Top of the master-side retry handler. Joins the window tracker, the
// ownership and reissue logic, and the grant and request gating.
// Assumes all bus strobes are active-low and sampled on the rising edge.
module bus_retry_handler #(
    parameter int OPEN_DELAY = 2,
    parameter int BLACKOUT   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need_bus,
    input  logic ts_n,
    input  logic ts_mine,
    input  logic aack_n,
    input  logic retry_n,
    input  logic grant_n,
    input  logic dbusy_n,
    output logic req_n,
    output logic grant_q_n,
    output logic abort_n,
    output logic reissue_n
);

    logic hit;
    logic win_last;
    logic reissue_pend;
    logic abort;

    rty_window #(.OPEN_DELAY(OPEN_DELAY)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .ts_n     (ts_n),
        .aack_n   (aack_n),
        .retry_n  (retry_n),
        .hit      (hit),
        .win_last (win_last)
    );

    rty_owner u_owner (
        .clk          (clk),
        .rst_n        (rst_n),
        .ts_n         (ts_n),
        .ts_mine      (ts_mine),
        .hit          (hit),
        .win_last     (win_last),
        .dbusy_n      (dbusy_n),
        .reissue_pend (reissue_pend),
        .abort        (abort)
    );

    rty_gate #(.BLACKOUT(BLACKOUT)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .grant_n      (grant_n),
        .need_bus     (need_bus),
        .reissue_pend (reissue_pend),
        .req_n        (req_n),
        .grant_q_n    (grant_q_n)
    );

    // Drive active-low status outputs
    always_comb begin
        abort_n   = !abort;
        reissue_n = !reissue_pend;
    end

endmodule

// File: rtl/bus_retry_handler_chk.sv
// Module: bus_retry_handler_chk
// Temporal checks on the retry handler, attached by bind.
// Assumes the default blackout of two cycles.
module bus_retry_handler_chk (
    input logic clk,
    input logic rst_n,
    input logic grant_n,
    input logic req_n,
    input logic grant_q_n,
    input logic abort_n,
    input logic reissue_n,
    input logic hit
);

    // R5
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |=> abort_n);

    // R4
    grant_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_q_n |-> !grant_n);

    // R4
    blackout_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |=> grant_q_n);

    // R6
    abort_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |=> !reissue_n);

    // R3
    hit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req_n && grant_q_n));

    // R6
    reissue_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reissue_n) |-> $past(hit));

endmodule

bind bus_retry_handler bus_retry_handler_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_n   (grant_n),
    .req_n     (req_n),
    .grant_q_n (grant_q_n),
    .abort_n   (abort_n),
    .reissue_n (reissue_n),
    .hit       (hit)
);

// File: tb/test_bus_retry_handler.sv
module test_bus_retry_handler;

    logic clk = 1'b0;
    logic rst_n;
    logic need_bus, ts_n, ts_mine, aack_n, retry_n, grant_n, dbusy_n;
    logic req_n, grant_q_n, abort_n, reissue_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bus_retry_handler i_bus_retry_handler (
        .clk       (clk),
        .rst_n     (rst_n),
        .need_bus  (need_bus),
        .ts_n      (ts_n),
        .ts_mine   (ts_mine),
        .aack_n    (aack_n),
        .retry_n   (retry_n),
        .grant_n   (grant_n),
        .dbusy_n   (dbusy_n),
        .req_n     (req_n),
        .grant_q_n (grant_q_n),
        .abort_n   (abort_n),
        .reissue_n (reissue_n)
    );

    // Row: [14:11] requirement number, [10:4] inputs
    // {ts_n, ts_mine, aack_n, retry_n, grant_n, dbusy_n, need_bus},
    // [3:0] expected {req_n, grant_q_n, abort_n, reissue_n}
    localparam int NV = 24;
    localparam logic [14:0] VEC [NV] = '{
        {4'd8,  7'b1011111, 4'b0111}, // c0  R8 idle, request follows need
        {4'd8,  7'b1011011, 4'b0011}, // c1  R8 grant passes
        {4'd8,  7'b0111011, 4'b0011}, // c2  R8 own transfer start
        {4'd1,  7'b1010101, 4'b0111}, // c3  R1 retry at T+1 ignored
        {4'd5,  7'b1010001, 4'b1101}, // c4  R5 retry at T+2 with data busy
        {4'd4,  7'b1000011, 4'b1110}, // c5  R4 grant blanked, aack
        {4'd9,  7'b1010001, 4'b0010}, // c6  R9 held retry not re-detected
        {4'd6,  7'b0111001, 4'b0010}, // c7  R6 reissue start
        {4'd6,  7'b1011110, 4'b1111}, // c8  R6 reissue cleared
        {4'd8,  7'b1001110, 4'b1111}, // c9  R8 aack, no need
        {4'd2,  7'b1010010, 4'b1111}, // c10 R2 retry at A+1, data idle
        {4'd3,  7'b1011010, 4'b1110}, // c11 R3 request held off
        {4'd8,  7'b1011010, 4'b0010}, // c12 R8 request back from reissue
        {4'd6,  7'b0111110, 4'b0110}, // c13 R6 reissue start
        {4'd6,  7'b1011110, 4'b1111}, // c14 R6 reissue cleared
        {4'd8,  7'b1001110, 4'b1111}, // c15 R8 aack
        {4'd8,  7'b1011110, 4'b1111}, // c16 R8 last cycle, no retry
        {4'd2,  7'b1010010, 4'b1011}, // c17 R2 retry at A+2 ignored
        {4'd8,  7'b0011111, 4'b0111}, // c18 R8 foreign transfer start
        {4'd8,  7'b1011111, 4'b0111}, // c19 R8 waiting
        {4'd7,  7'b1010001, 4'b1111}, // c20 R7 observer retry, no abort
        {4'd3,  7'b1010001, 4'b1111}, // c21 R3 observer request held off
        {4'd9,  7'b1000001, 4'b0011}, // c22 R9 held retry, grant passes
        {4'd4,  7'b1011001, 4'b0011}  // c23 R4 grant follows input
    };

    task automatic chk(input int req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: outputs {req_n,grant_q_n,abort_n,reissue_n} = %b, expected %b",
                     req, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        @(negedge clk);
        {ts_n, ts_mine, aack_n, retry_n, grant_n, dbusy_n, need_bus} = v;
        #2;
    endtask

    function automatic logic [3:0] outs();
        return {req_n, grant_q_n, abort_n, reissue_n};
    endfunction

    initial begin
        rst_n = 1'b0;
        {ts_n, ts_mine, aack_n, retry_n, grant_n, dbusy_n, need_bus} = 7'b1011010;
        repeat (3) @(posedge clk);
        drive(7'b1011010);
        chk(10, outs(), 4'b1011); // R10 reset state, grant passes through
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][10:4]);
            chk(int'(VEC[i][14:11]), outs(), VEC[i][3:0]);
        end

        // Directed: acknowledge in T+1 gives a single legal cycle at T+2 (R1, R2)
        drive(7'b0111110);
        drive(7'b1001110);
        drive(7'b1010110);
        chk(2, outs(), 4'b1111); // R2 detected at A+1 = T+2, data idle
        drive(7'b1011110);
        chk(6, outs(), 4'b1110); // R6 reissue pending

        // Directed: reset clears a pending reissue (R10)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(10, outs(), 4'b1111); // R10 reissue cleared, no need
        drive(7'b1011111);
        chk(10, outs(), 4'b0111); // R10 request follows need only

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung, expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule